// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block raises port-to-port interrupts for a memory shared by a left and a right port. The two topmost words of the address space act as mailboxes: the all-ones word belongs to the right port and the word just below it belongs to the left port. The block watches each port's enable, write strobe and address on every clock edge. It stores no message data, because that data stays in the memory. It does not arbitrate between the ports.

When one port writes into the other port's mailbox, the mailbox owner's interrupt is asserted. The owner acknowledges the interrupt by reading its own mailbox. Each port has a contention BUSY input. While that input is high, the port's accesses can neither set nor clear an interrupt. Both interrupt outputs are active low and registered.

Top module: `mbox_irq`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, both `lp_irq_n` and `rp_irq_n` are high.
- R2: A left-port write (`lp_en`=1, `lp_we`=1, `lp_busy`=0) to address 2^AW-1 drives `rp_irq_n` low from the clock edge that samples it.
- R3: A right-port write (`rp_en`=1, `rp_we`=1, `rp_busy`=0) to address 2^AW-2 drives `lp_irq_n` low from the clock edge that samples it.
- R4: A right-port read (`rp_we`=0) of 2^AW-1 with `rp_busy`=0 drives `rp_irq_n` high. A left-port read of 2^AW-2 with `lp_busy`=0 drives `lp_irq_n` high.
- R5: No other access changes an interrupt. This covers a port reading the other port's mailbox, a port writing its own mailbox, any access to a non-mailbox address, and any cycle with the enable low.
- R6: While a port's busy input is 1, its writes cannot set the other port's interrupt, and its read of its own mailbox cannot clear its own interrupt.
- R7: If a set and a clear of the same interrupt are sampled on the same edge, the interrupt ends up asserted (low).
- R8: The address width AW is a parameter. The mailbox addresses are derived from it as all-ones and all-ones minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lp_en | input | 1 | Left port access valid this cycle |
| lp_we | input | 1 | Left port write (1) or read (0) |
| lp_addr | input | AW | Left port word address |
| lp_busy | input | 1 | Left port lost contention; its access has no interrupt effect |
| rp_en | input | 1 | Right port access valid this cycle |
| rp_we | input | 1 | Right port write (1) or read (0) |
| rp_addr | input | AW | Right port word address |
| rp_busy | input | 1 | Right port lost contention; its access has no interrupt effect |
| lp_irq_n | output | 1 | Left port interrupt, active low |
| rp_irq_n | output | 1 | Right port interrupt, active low |

## Verification
Directed sequences first set and clear each interrupt on its own. They then repeat each access with busy held high, with the two mailboxes swapped, and with a set and a clear on the same edge. These sequences separate a correct address decode from a decode that has the two mailboxes swapped, and a correct priority from one where the clear wins. A sweep with AW=4 then steps through every combination of enable, direction, busy and all sixteen addresses on both ports at once, and compares against an arithmetic model after every edge. The sweep shows whether any non-mailbox address, a disabled port, or a read of the other port's mailbox leaks into the flags.

// File: rtl/mbox_irq.sv
module mbox_irq #(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lp_en,
  input  logic          lp_we,
  input  logic [AW-1:0] lp_addr,
  input  logic          lp_busy,
  input  logic          rp_en,
  input  logic          rp_we,
  input  logic [AW-1:0] rp_addr,
  input  logic          rp_busy,
  output logic          lp_irq_n,
  output logic          rp_irq_n
);

  localparam logic [AW-1:0] R_BOX = {AW{1'b1}};
  localparam logic [AW-1:0] L_BOX = R_BOX - 1'b1;

  logic lp_go, rp_go;
  logic set_l, clr_l, set_r, clr_r;
  logic pend_l, pend_r;

  assign lp_go = lp_en & ~lp_busy;
  assign rp_go = rp_en & ~rp_busy;

  assign set_r = lp_go &  lp_we & (lp_addr == R_BOX);
  assign clr_r = rp_go & ~rp_we & (rp_addr == R_BOX);
  assign set_l = rp_go &  rp_we & (rp_addr == L_BOX);
  assign clr_l = lp_go & ~lp_we & (lp_addr == L_BOX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_l <= 1'b0;
      pend_r <= 1'b0;
    end else begin
      pend_l <= set_l | (pend_l & ~clr_l);
      pend_r <= set_r | (pend_r & ~clr_r);
    end
  end

  assign lp_irq_n = ~pend_l;
  assign rp_irq_n = ~pend_r;

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (lp_irq_n && rp_irq_n)); // R1

  AST_RIGHT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_en && lp_we && !lp_busy && lp_addr == R_BOX) |=> !rp_irq_n); // R2

  AST_LEFT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rp_en && rp_we && !rp_busy && rp_addr == L_BOX) |=> !lp_irq_n); // R3

  AST_RIGHT_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rp_irq_n && rp_en && !rp_we && !rp_busy && rp_addr == R_BOX &&
     !(lp_en && lp_we && !lp_busy && lp_addr == R_BOX)) |=> rp_irq_n); // R4

  AST_BOTH_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_busy && rp_busy) |=> ($stable(lp_irq_n) && $stable(rp_irq_n))); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!lp_en && !rp_en) |=> ($stable(lp_irq_n) && $stable(rp_irq_n))); // R5

endmodule

// File: tb/mbox_irq_bench.sv
module mbox_irq_bench;
  localparam int AW = 4;
  localparam int TOPA = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic lp_en, lp_we, lp_busy, rp_en, rp_we, rp_busy;
  logic [AW-1:0] lp_addr, rp_addr;
  logic lp_irq_n, rp_irq_n;
  int checks = 0;
  int failures = 0;
  bit el, er;

  always #10 clk = ~clk;

  mbox_irq #(.AW(AW)) u_mbox_irq (
    .clk(clk), .rst_n(rst_n),
    .lp_en(lp_en), .lp_we(lp_we), .lp_addr(lp_addr), .lp_busy(lp_busy),
    .rp_en(rp_en), .rp_we(rp_we), .rp_addr(rp_addr), .rp_busy(rp_busy),
    .lp_irq_n(lp_irq_n), .rp_irq_n(rp_irq_n)
  );

  task automatic chk(input string tag, input bit exp_l, input bit exp_r);
    checks++;
    if (lp_irq_n !== exp_l || rp_irq_n !== exp_r) begin
      failures++;
      $display("FAIL %s: lp_irq_n=%b rp_irq_n=%b expected %b %b", tag, lp_irq_n, rp_irq_n, exp_l, exp_r);
    end
  endtask

  task automatic drive(input bit le, input bit lw, input int la, input bit lb,
                       input bit re, input bit rw, input int ra, input bit rb);
    @(negedge clk);
    lp_en = le; lp_we = lw; lp_addr = la[AW-1:0]; lp_busy = lb;
    rp_en = re; rp_we = rw; rp_addr = ra[AW-1:0]; rp_busy = rb;
    @(posedge clk); #1;
    lp_en = 1'b0; rp_en = 1'b0;
  endtask

  function automatic void model(input bit le, input bit lw, input int la, input bit lb,
                                input bit re, input bit rw, input int ra, input bit rb);
    bit sr, cr, sl, cl;
    sr = le && lw && !lb && la == TOPA;
    cr = re && !rw && !rb && ra == TOPA;
    sl = re && rw && !rb && ra == TOPA - 1;
    cl = le && !lw && !lb && la == TOPA - 1;
    if (sr) er = 1'b0; else if (cr) er = 1'b1;
    if (sl) el = 1'b0; else if (cl) el = 1'b1;
  endfunction

  initial begin
    #3_000_000;
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    lp_en = 0; lp_we = 0; lp_addr = '0; lp_busy = 0;
    rp_en = 0; rp_we = 0; rp_addr = '0; rp_busy = 0;
    repeat (2) @(posedge clk);
    #1 chk("R1 during reset", 1, 1);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1 chk("R1 after reset", 1, 1);

    drive(1,1,TOPA,0, 0,0,0,0);        chk("R2 left write sets right", 1, 0);
    drive(0,0,0,0, 1,0,TOPA-1,0);      chk("R5 right reads other box", 1, 0);
    drive(1,1,TOPA-1,0, 0,0,0,0);      chk("R5 left writes own box", 1, 0);
    drive(0,0,0,0, 1,0,TOPA,1);        chk("R6 busy blocks clear", 1, 0);
    drive(0,0,0,0, 1,0,TOPA,0);        chk("R4 right read clears", 1, 1);
    drive(0,0,0,0, 1,1,TOPA-1,0);      chk("R3 right write sets left", 0, 1);
    drive(1,0,TOPA,0, 0,0,0,0);        chk("R5 left reads other box", 0, 1);
    drive(1,0,TOPA-1,1, 0,0,0,0);      chk("R6 left busy blocks clear", 0, 1);
    drive(1,0,TOPA-1,0, 0,0,0,0);      chk("R4 left read clears", 1, 1);
    drive(1,1,TOPA,1, 1,1,TOPA-1,1);   chk("R6 busy blocks sets", 1, 1);
    drive(1,1,5,0, 1,1,TOPA-2,0);      chk("R8 non-mailbox addresses", 1, 1);
    drive(0,1,TOPA,0, 0,1,TOPA-1,0);   chk("R5 disabled ports", 1, 1);
    drive(1,1,TOPA,0, 0,0,0,0);        chk("R7 setup", 1, 0);
    drive(1,1,TOPA,0, 1,0,TOPA,0);     chk("R7 set beats clear right", 1, 0);
    drive(1,0,TOPA-1,0, 1,1,TOPA-1,0); chk("R7 set beats clear left", 0, 0);

    el = lp_irq_n; er = rp_irq_n;
    for (int l = 0; l < 128; l++) begin
      for (int r = 0; r < 128; r++) begin
        drive(l[6], l[5], l[3:0], l[4], r[6], r[5], r[3:0], r[4]);
        model(l[6], l[5], l[3:0], l[4], r[6], r[5], r[3:0], r[4]);
        chk("R5/R6/R7/R8 sweep", el, er);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule